// File: doc/BRIEF.md
# Linked Command-List Length Walker

This block follows a chain of command nodes stored in a word-addressed memory and works out how many 32-bit words a transfer of the whole chain would move. A node is one header word, which may be followed by payload words. The top byte of the header gives the payload length in words. The low 24 bits point to the next node. A pointer of all ones marks the end of the chain. The walker reads only the headers. It never fetches or forwards the payload.

A walk begins when a start strobe arrives together with a start pointer. The walker then issues one read at a time on a simple synchronous memory port, and each read returns its word one cycle later. The walk ends in one of three ways: the end marker is found, a cheap three-entry address tracker spots a revisit, or a node budget is exceeded. At that point the block raises a one-cycle done pulse and holds two results: the saturated word total and a stop reason. This lets a DMA engine size a command list before it schedules the list.

Top module: `chain_walker`

## Requirements
- R1: Each read address is the current pointer with bits 23:21 and bits 1:0 forced to zero (pointer AND 0x1FFFFC). This applies both to the start pointer and to every followed pointer.
- R2: The total starts at 1. For every node visited it grows by the header's bits 31:24 plus one.
- R3: The next pointer is taken from header bits 23:0 before masking. When it equals 0xFFFFFF the walk ends with stop code 0.
- R4: A tracker holds three addresses: last, low and high, all reset to 0xFFFFFF when a walk starts. If the masked address about to be visited equals low or high, the walk stops with code 1 and that node is not counted. Otherwise the address goes into low if it is below last, or into high if it is not, and then becomes last.
- R5: If the number of nodes already visited exceeds NODE_CAP, the walk stops with code 2 before it reads another node. A chain of exactly NODE_CAP+1 nodes therefore still ends with code 0. The node-cap test comes before the loop test.
- R6: The total saturates at 2^CNT_W-1 and never wraps.
- R7: mem_req_o is high for one cycle per node. mem_rdata_i is used on the cycle after the request. No second request is issued until that node has been processed.
- R8: busy_o is high from the cycle after an accepted start up to and including the single done_o cycle. After done, word_count_o and stop_code_o hold their values until the next accepted start.
- R9: A start strobe that arrives while busy_o is high is ignored. The walk in progress continues unchanged.
- R10: After reset, busy_o, done_o and mem_req_o are low, and word_count_o and stop_code_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, accepted only when idle |
| start_addr_i | input | 24 | Pointer to the first node |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | ADDR_W | Byte address of the word to read, word aligned |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the request |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse when the walk ends |
| word_count_o | output | CNT_W | Accumulated word total |
| stop_code_o | output | 2 | Stop reason: 0 end, 1 loop, 2 node cap |

## Verification
The hardest cases to reach are the loop tracker's misses and hits, and the node cap. Which one happens depends on the order of node addresses in memory, not on any single input. To reach them, the bench builds chains on a small grid of word slots. It permutes the slots with a stride-7 pattern under several seeds and points the tail back at every possible earlier node. This produces ascending, descending and mixed revisit patterns. Some of these the tracker catches, and others run on until the reduced node cap stops them.

// File: rtl/chain_walker_pkg.sv
package chain_walker_pkg;
  localparam int unsigned PTR_W = 24;
  localparam int unsigned LEN_W = 8;
  localparam logic [PTR_W-1:0] END_PTR = {PTR_W{1'b1}};

  typedef enum logic [1:0] {
    STOP_END  = 2'd0,
    STOP_LOOP = 2'd1,
    STOP_CAP  = 2'd2
  } stop_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_UPD,
    ST_DONE
  } walk_st_e;
endpackage

// File: rtl/cw_loop_guard.sv
module cw_loop_guard
  import chain_walker_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             probe_i,
  input  logic [PTR_W-1:0] addr_i,
  output logic             hit_o
);
  logic [PTR_W-1:0] last_q, lo_q, hi_q;

  assign hit_o = (addr_i == lo_q) || (addr_i == hi_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= END_PTR;
      lo_q   <= END_PTR;
      hi_q   <= END_PTR;
    end else if (clear_i) begin
      last_q <= END_PTR;
      lo_q   <= END_PTR;
      hi_q   <= END_PTR;
    end else if (probe_i && !hit_o) begin
      if (addr_i < last_q) lo_q <= addr_i;
      else                 hi_q <= addr_i;
      last_q <= addr_i;
    end
  end
endmodule

// File: rtl/cw_node_cap.sv
module cw_node_cap #(
  parameter int unsigned NODE_CAP = 2000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic inc_i,
  output logic over_o
);
  localparam int unsigned VIS_W = $clog2(NODE_CAP + 2) + 1;
  localparam logic [VIS_W-1:0] CAP_V = VIS_W'(NODE_CAP);

  logic [VIS_W-1:0] visits_q;

  assign over_o = visits_q > CAP_V;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          visits_q <= '0;
    else if (clear_i)                     visits_q <= '0;
    else if (inc_i && !(&visits_q))       visits_q <= visits_q + 1'b1;
  end
endmodule

// File: rtl/cw_sat_acc.sv
module cw_sat_acc
  import chain_walker_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             add_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [CNT_W-1:0] sum_o
);
  localparam int unsigned EXT_W = CNT_W + LEN_W + 1;
  localparam logic [EXT_W-1:0] MAX_V = EXT_W'({CNT_W{1'b1}});

  logic [CNT_W-1:0] acc_q;
  logic [EXT_W-1:0] sum_ext;

  assign sum_ext = EXT_W'(acc_q) + EXT_W'(len_i) + EXT_W'(1);
  assign sum_o   = acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (load_i) acc_q <= CNT_W'(1);
    else if (add_i)  acc_q <= (sum_ext > MAX_V) ? {CNT_W{1'b1}} : sum_ext[CNT_W-1:0];
  end
endmodule

// File: rtl/chain_walker.sv
module chain_walker
  import chain_walker_pkg::*;
#(
  parameter int unsigned ADDR_W   = 21,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NODE_CAP = 2000000
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            start_i,
  input  logic [chain_walker_pkg::PTR_W-1:0] start_addr_i,
  output logic                            mem_req_o,
  output logic [ADDR_W-1:0]               mem_addr_o,
  input  logic [31:0]                     mem_rdata_i,
  output logic                            busy_o,
  output logic                            done_o,
  output logic [CNT_W-1:0]                word_count_o,
  output logic [1:0]                      stop_code_o
);
  localparam logic [PTR_W-1:0] ADDR_MASK =
    {{(PTR_W-ADDR_W){1'b0}}, {(ADDR_W-2){1'b1}}, 2'b00};

  walk_st_e         state_q;
  stop_e            stop_q;
  logic [PTR_W-1:0] cur_q, cur_m;
  logic [31:0]      hdr_q;
  logic             accept, cap_hit, loop_hit, req_ok;

  assign cur_m    = cur_q & ADDR_MASK;
  assign accept   = (state_q == ST_IDLE) && start_i;
  // cap is checked first; a capped walk never touches the loop tracker
  assign req_ok   = (state_q == ST_REQ) && !cap_hit && !loop_hit;

  assign mem_req_o    = req_ok;
  assign mem_addr_o   = cur_m[ADDR_W-1:0];
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = (state_q == ST_DONE);
  assign stop_code_o  = stop_q;

  cw_loop_guard u_guard (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .probe_i ((state_q == ST_REQ) && !cap_hit),
    .addr_i  (cur_m),
    .hit_o   (loop_hit)
  );

  cw_node_cap #(.NODE_CAP(NODE_CAP)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .inc_i   (req_ok),
    .over_o  (cap_hit)
  );

  cw_sat_acc #(.CNT_W(CNT_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .add_i   (state_q == ST_UPD),
    .len_i   (hdr_q[31:24]),
    .sum_o   (word_count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      stop_q  <= STOP_END;
      cur_q   <= '0;
      hdr_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          cur_q   <= start_addr_i;
          stop_q  <= STOP_END;
          state_q <= ST_REQ;
        end
        ST_REQ: begin
          if (cap_hit) begin
            stop_q  <= STOP_CAP;
            state_q <= ST_DONE;
          end else if (loop_hit) begin
            stop_q  <= STOP_LOOP;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          hdr_q   <= mem_rdata_i;
          state_q <= ST_UPD;
        end
        ST_UPD: begin
          if (hdr_q[PTR_W-1:0] == END_PTR) begin
            stop_q  <= STOP_END;
            state_q <= ST_DONE;
          end else begin
            cur_q   <= hdr_q[PTR_W-1:0];
            state_q <= ST_REQ;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chain_walker_chk.sv
module chain_walker_chk #(
  parameter int unsigned ADDR_W   = 21,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned NODE_CAP = 2000000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  word_count_o,
  input logic [1:0]        stop_code_o
);
  int unsigned req_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   req_cnt <= 0;
    else if (start_i && !busy_o)   req_cnt <= 0;
    else if (mem_req_o)            req_cnt <= req_cnt + 1;
  end

  // R1
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  // R7
  single_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  // R8
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  // R2
  count_mono_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> (word_count_o >= $past(word_count_o)));

  // R3
  stop_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (stop_code_o != 2'd3));

  // R5
  node_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_cnt <= NODE_CAP + 1);

  // R9
  start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && start_i) |=> busy_o);

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
endmodule

bind chain_walker chain_walker_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NODE_CAP(NODE_CAP)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .mem_req_o    (mem_req_o),
  .mem_addr_o   (mem_addr_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .word_count_o (word_count_o),
  .stop_code_o  (stop_code_o)
);

// File: tb/chain_walker_bench.sv
`timescale 1ns/1ps
module chain_walker_bench;
  localparam int unsigned ADDR_W = 21;
  localparam int unsigned CNT_W  = 10;
  localparam int unsigned CAP    = 6;
  localparam longint      MAXC   = (64'd1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [23:0]       start_addr = '0;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_rdata = '0;
  logic              busy, done;
  logic [CNT_W-1:0]  wcount;
  logic [1:0]        scode;

  int n_vec = 0;
  int n_err = 0;
  bit finished = 0;

  logic [31:0]       mem [64];
  logic [ADDR_W-1:0] log_q[$];
  logic [ADDR_W-1:0] exp_addrs[$];
  longint            exp_cnt;
  int                exp_code;

  always #4 clk = ~clk;

  chain_walker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NODE_CAP(CAP)) u_chain_walker (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(start_addr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .word_count_o(wcount), .stop_code_o(scode)
  );

  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[7:2]];
  always @(negedge clk) if (mem_req) log_q.push_back(mem_addr);

  task automatic chk(input string req, input longint act, input longint exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 32'h00FF_FFFF;
  endtask

  // reference walk computed from the requirement text
  task automatic ref_walk(input logic [23:0] st);
    logic [23:0] a, am, last, lo, hi;
    logic [31:0] w;
    int visits;
    a = st; last = 24'hFFFFFF; lo = 24'hFFFFFF; hi = 24'hFFFFFF;
    visits = 0; exp_cnt = 1; exp_addrs.delete();
    for (int it = 0; it < 100; it++) begin
      am = a & 24'h1FFFFC;
      if (visits > CAP) begin exp_code = 2; break; end
      if (am == lo || am == hi) begin exp_code = 1; break; end
      if (am < last) lo = am; else hi = am;
      last = am;
      visits++;
      exp_addrs.push_back(am[ADDR_W-1:0]);
      w = mem[am[7:2]];
      exp_cnt = exp_cnt + longint'(w[31:24]) + 1;
      if (exp_cnt > MAXC) exp_cnt = MAXC;
      if (w[23:0] == 24'hFFFFFF) begin exp_code = 0; break; end
      a = w[23:0];
    end
  endtask

  function automatic logic [23:0] slot(input int i, input int seed);
    return 24'(((i * 7 + seed) % 16) * 16 + 4 * (seed % 4));
  endfunction

  // back < 0: linear chain; len < 0: formula length
  task automatic build_chain(input int n, input int seed, input int back, input int len,
                             output logic [23:0] st);
    logic [23:0] nxt;
    int l;
    clear_mem();
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) nxt = (back < 0) ? 24'hFFFFFF : slot(back, seed) | 24'hA00002;
      else nxt = slot(i + 1, seed) | (((i + seed) % 2 == 1) ? 24'hA00000 : 24'h0) | 24'(i % 4);
      l = (len < 0) ? ((n * 53 + i * 29 + seed * 11 + 7) & 255) : len;
      mem[slot(i, seed) >> 2] = {8'(l), nxt};
    end
    st = slot(0, seed) | 24'h600001;
  endtask

  task automatic run_walk(input logic [23:0] st, input bit poke, input string tag);
    int cyc;
    logic [CNT_W-1:0] held;
    string ct;
    ref_walk(st);
    log_q.delete();
    @(negedge clk); start_addr = st; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      start_addr = 24'h000040; start = 1'b1;   // R9: must be ignored
      @(negedge clk); start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    chk({tag, " R8 done seen"}, done, 1);
    ct = (exp_code == 0) ? "R3" : (exp_code == 1) ? "R4" : "R5";
    chk({tag, " R2 count"}, wcount, exp_cnt);
    chk({tag, " ", ct, " stop code"}, scode, exp_code);
    chk({tag, " R1 R7 read count"}, log_q.size(), exp_addrs.size());
    for (int i = 0; i < exp_addrs.size() && i < log_q.size(); i++)
      chk({tag, " R1 address"}, log_q[i], exp_addrs[i]);
    held = wcount;
    @(negedge clk);
    chk({tag, " R8 pulse"}, done, 0);
    chk({tag, " R8 idle"}, busy, 0);
    repeat (3) @(negedge clk);
    chk({tag, " R8 hold count"}, wcount, held);
    chk({tag, " R8 hold code"}, scode, exp_code);
  endtask

  initial begin
    logic [23:0] st;
    clear_mem();
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 req", mem_req, 0);
    chk("R10 count", wcount, 0);
    chk("R10 code", scode, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // linear chains around the cap boundary (R3, R5)
    for (int seed = 0; seed < 4; seed++)
      for (int n = 1; n <= CAP + 3; n++) begin
        build_chain(n, seed, -1, -1, st);
        run_walk(st, 1'b0, "linear");
      end

    // tail pointing back at each earlier node (R4, R5)
    for (int seed = 0; seed < 5; seed++)
      for (int n = 1; n <= CAP; n++)
        for (int b = 0; b < n; b++) begin
          build_chain(n, seed, b, -1, st);
          run_walk(st, 1'b0, "loop");
        end

    // R6 saturation: 3 nodes fit, 4 nodes clamp
    build_chain(3, 1, -1, 255, st);
    run_walk(st, 1'b0, "sat3");
    chk("R6 no clamp", wcount, 769);
    build_chain(4, 1, -1, 255, st);
    run_walk(st, 1'b0, "sat4");
    chk("R6 clamp", wcount, MAXC);

    // R9 start while busy
    build_chain(5, 2, -1, -1, st);
    run_walk(st, 1'b1, "R9 restart");

    // R1 all-ones start pointer masks to 0x1FFFFC
    clear_mem();
    mem[63] = {8'd3, 24'hFFFFFF};
    run_walk(24'hFFFFFF, 1'b0, "R1 top");
    chk("R1 top count", wcount, 5);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule